// File: doc/BRIEF.md
# SPI Three-Axis Accelerometer Polling Controller

This block brings a three-axis accelerometer on an SPI bus out of reset and into measurement, and then reads it back-to-back for as long as it runs. It needs no commands. After reset it sends two 24-bit register writes. The first writes the output-data-rate and range settings taken from parameters. The second switches the sensor into measurement mode. After that it issues one 64-bit burst read after another. From each burst it takes the X, Y and Z samples and presents them together on three 12-bit output buses.

The SPI side runs in mode 0: SCLK idles low, data is sampled on the rising edge and changed on the falling edge. The SCLK half period is derived from the system clock frequency parameter, so that SCLK never exceeds 8 MHz. Between any two frames, chip select stays high for at least 200 ns. The active-low reset acts at once. It lifts chip select, parks SCLK and zeroes the sample buses. When reset is released, the whole configuration sequence runs again before polling resumes.

Top module: `accel_poll_ctrl`

## Requirements
- R1: While reset is asserted, `cs_n` is 1, `sclk` is 0 and all three acceleration buses are zero.
- R2: Chip select stays high for at least 200 ns between the end of one frame and the start of the next.
- R3: The first frame after reset is 24 bits long. It carries, MSB first, the write command 0x0A, the address 0x2C, and a data byte holding the range code in bits [7:6], zeros in bits [5:3] and the rate code in bits [2:0]. With range 2'b00 and rate 3'b011 the byte is 0x03. With range 2'b11 and rate 3'b101 it is 0xC5.
- R4: The second frame is 24 bits long and carries 0x0A, 0x2D, 0x02.
- R5: Every later frame is 64 bits long and begins with the read command 0x0B followed by the start address 0x0E. Chip select stays low for the whole frame.
- R6: SPI mode 0 holds throughout. SCLK is low whenever chip select is high. MOSI does not change while SCLK is high inside a frame. The SCLK period is at least 125 ns.
- R7: The six bytes received after the two command bytes are X low, X high, Y low, Y high, Z low and Z high. Each bus takes the low 12 bits of {high, low}. All three buses update together once a read frame ends, and they keep their values until the next read frame ends.
- R8: Asserting reset in the middle of a frame lifts chip select and zeroes the buses without waiting for a clock. After release, the controller again sends the two configuration frames (R3, R4) before it reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miso | input | 1 | Serial data from the sensor |
| sclk | output | 1 | SPI serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the sensor |
| acc_x | output | 12 | Latest X-axis sample |
| acc_y | output | 12 | Latest Y-axis sample |
| acc_z | output | 12 | Latest Z-axis sample |

## Verification
The assertions assume the sensor only changes MISO while SCLK is low, so that the value sampled at the rising edge has been stable for a full half period. The bench's slave model keeps to this: it updates MISO only when chip select falls and on falling SCLK edges. The assertions also assume that reset is released only through the internal synchronizer. The bench therefore drives `rst_n` away from the clock edge and holds it for many cycles. The slave returns a different, arithmetically generated sample set in every frame, with junk in the unused upper nibbles, so that a stale latch, swapped bytes or a missing mask all show up as a mismatch.

// File: rtl/accel_poll_pkg.sv
`timescale 1ns/1ps
package accel_poll_pkg;

  typedef enum logic [2:0] {
    SQ_START,
    SQ_PAUSE,
    SQ_CFG,
    SQ_READ,
    SQ_OUT
  } seq_state_e;

  typedef enum logic [1:0] {
    SE_IDLE,
    SE_LOW,
    SE_HIGH,
    SE_TAIL
  } spi_state_e;

  localparam logic [7:0] CMD_WRITE  = 8'h0A;
  localparam logic [7:0] CMD_READ   = 8'h0B;
  localparam logic [7:0] ADDR_FILT  = 8'h2C;
  localparam logic [7:0] ADDR_POWER = 8'h2D;
  localparam logic [7:0] POWER_MEAS = 8'h02;
  localparam logic [7:0] ADDR_XLOW  = 8'h0E;

  localparam int CFG_BITS  = 24;
  localparam int HEAD_BITS = 16;

endpackage

// File: rtl/accel_spi_engine.sv
`timescale 1ns/1ps
// Mode-0 SPI master: one frame of 1..FRAME_W bits per start pulse, chip select held low for the whole frame.
module accel_spi_engine
  import accel_poll_pkg::*;
#(
  parameter int HALF_CYC = 16,
  parameter int FRAME_W  = 64,
  parameter int RX_W     = 48,
  localparam int LEN_W   = $clog2(FRAME_W + 1),
  localparam int HC_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   len,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               miso,
  output logic               busy,
  output logic               done,
  output logic [RX_W-1:0]    rx_data,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi
);

  spi_state_e         st_q, st_n;
  logic [HC_W-1:0]    hc_q, hc_n;
  logic [LEN_W-1:0]   bit_q, bit_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic [RX_W-1:0]    rx_q, rx_n;
  logic               sclk_q, sclk_n;
  logic               cs_q, cs_n_nxt;
  logic               done_q, done_n;
  logic               half_end;

  assign half_end = (hc_q == HC_W'(HALF_CYC - 1));

  always_comb begin
    st_n     = st_q;
    hc_n     = hc_q;
    bit_n    = bit_q;
    len_n    = len_q;
    tx_n     = tx_q;
    rx_n     = rx_q;
    sclk_n   = sclk_q;
    cs_n_nxt = cs_q;
    done_n   = 1'b0;
    case (st_q)
      SE_IDLE: begin
        if (start) begin
          st_n     = SE_LOW;
          hc_n     = '0;
          bit_n    = '0;
          len_n    = len;
          tx_n     = tx_data;
          cs_n_nxt = 1'b0;
        end
      end
      SE_LOW: begin
        if (half_end) begin
          hc_n   = '0;
          sclk_n = 1'b1;
          rx_n   = {rx_q[RX_W-2:0], miso};
          st_n   = SE_HIGH;
        end else begin
          hc_n = hc_q + HC_W'(1);
        end
      end
      SE_HIGH: begin
        if (half_end) begin
          hc_n   = '0;
          sclk_n = 1'b0;
          if (bit_q == len_q - LEN_W'(1)) begin
            st_n = SE_TAIL;
          end else begin
            bit_n = bit_q + LEN_W'(1);
            tx_n  = {tx_q[FRAME_W-2:0], 1'b0};
            st_n  = SE_LOW;
          end
        end else begin
          hc_n = hc_q + HC_W'(1);
        end
      end
      SE_TAIL: begin
        if (half_end) begin
          hc_n     = '0;
          cs_n_nxt = 1'b1;
          done_n   = 1'b1;
          st_n     = SE_IDLE;
        end else begin
          hc_n = hc_q + HC_W'(1);
        end
      end
      default: st_n = SE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SE_IDLE;
      hc_q   <= '0;
      bit_q  <= '0;
      len_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      hc_q   <= hc_n;
      bit_q  <= bit_n;
      len_q  <= len_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      sclk_q <= sclk_n;
      cs_q   <= cs_n_nxt;
      done_q <= done_n;
    end
  end

  assign busy    = (st_q != SE_IDLE);
  assign done    = done_q;
  assign rx_data = rx_q;
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = tx_q[FRAME_W-1];

  // Checker state: cycles since SCLK last toggled (saturating).
  logic            sclk_d;
  logic [HC_W:0]   tog_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      tog_cnt <= '1;
    end else begin
      sclk_d <= sclk_q;
      if (sclk_q != sclk_d) begin
        tog_cnt <= '0;
      end else if (tog_cnt != '1) begin
        tog_cnt <= tog_cnt + 1'b1;
      end
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n); // R6
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R6
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q != sclk_d) |-> (tog_cnt >= (HC_W+1)'(HALF_CYC - 1))); // R6
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> cs_n); // R5

endmodule

// File: rtl/accel_seq.sv
`timescale 1ns/1ps
// Startup-then-poll sequencer: two configuration writes, then endless burst reads.
module accel_seq
  import accel_poll_pkg::*;
#(
  parameter int          GAP_CYC    = 50,
  parameter int          FRAME_W    = 64,
  parameter int          RX_W       = 48,
  parameter int          AXIS_W     = 12,
  parameter logic [2:0]  RATE_CODE  = 3'b011,
  parameter logic [1:0]  RANGE_CODE = 2'b00,
  localparam int LEN_W = $clog2(FRAME_W + 1),
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_busy,
  input  logic               spi_done,
  input  logic [RX_W-1:0]    rx_data,
  output logic               spi_start,
  output logic [LEN_W-1:0]   spi_len,
  output logic [FRAME_W-1:0] spi_tx,
  output logic [AXIS_W-1:0]  acc_x,
  output logic [AXIS_W-1:0]  acc_y,
  output logic [AXIS_W-1:0]  acc_z
);

  localparam logic [7:0] FILT_BYTE = {RANGE_CODE, 3'b000, RATE_CODE};
  localparam logic [FRAME_W-1:0] TX_CFG0 =
    {CMD_WRITE, ADDR_FILT, FILT_BYTE, {(FRAME_W-CFG_BITS){1'b0}}};
  localparam logic [FRAME_W-1:0] TX_CFG1 =
    {CMD_WRITE, ADDR_POWER, POWER_MEAS, {(FRAME_W-CFG_BITS){1'b0}}};
  localparam logic [FRAME_W-1:0] TX_READ =
    {CMD_READ, ADDR_XLOW, {(FRAME_W-HEAD_BITS){1'b0}}};

  seq_state_e         st_q, st_n;
  logic [GAP_W-1:0]   gap_q, gap_n;
  logic [1:0]         step_q, step_n;
  logic               start_q, start_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic               acc_en;
  logic [AXIS_W-1:0]  acc_x_q, acc_y_q, acc_z_q;
  logic [15:0]        x_word, y_word, z_word;
  logic               gap_end;

  assign gap_end = (gap_q == GAP_W'(GAP_CYC - 1));

  // Burst byte order after the two command bytes: XL XH YL YH ZL ZH.
  assign x_word = {rx_data[39:32], rx_data[47:40]};
  assign y_word = {rx_data[23:16], rx_data[31:24]};
  assign z_word = {rx_data[7:0],   rx_data[15:8]};

  always_comb begin
    st_n    = st_q;
    gap_n   = gap_q;
    step_n  = step_q;
    start_n = 1'b0;
    len_n   = len_q;
    tx_n    = tx_q;
    acc_en  = 1'b0;
    case (st_q)
      SQ_START: begin
        gap_n  = '0;
        step_n = 2'd0;
        st_n   = SQ_PAUSE;
      end
      SQ_PAUSE: begin
        if (gap_end) begin
          start_n = 1'b1;
          if (step_q == 2'd0) begin
            len_n = LEN_W'(CFG_BITS);
            tx_n  = TX_CFG0;
            st_n  = SQ_CFG;
          end else if (step_q == 2'd1) begin
            len_n = LEN_W'(CFG_BITS);
            tx_n  = TX_CFG1;
            st_n  = SQ_CFG;
          end else begin
            len_n = LEN_W'(FRAME_W);
            tx_n  = TX_READ;
            st_n  = SQ_READ;
          end
        end else begin
          gap_n = gap_q + GAP_W'(1);
        end
      end
      SQ_CFG: begin
        if (spi_done) begin
          step_n = step_q + 2'd1;
          gap_n  = '0;
          st_n   = SQ_PAUSE;
        end
      end
      SQ_READ: begin
        if (spi_done) begin
          st_n = SQ_OUT;
        end
      end
      SQ_OUT: begin
        acc_en = 1'b1;
        gap_n  = '0;
        st_n   = SQ_PAUSE;
      end
      default: st_n = SQ_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_START;
      gap_q   <= '0;
      step_q  <= 2'd0;
      start_q <= 1'b0;
      len_q   <= '0;
      tx_q    <= '0;
    end else begin
      st_q    <= st_n;
      gap_q   <= gap_n;
      step_q  <= step_n;
      start_q <= start_n;
      len_q   <= len_n;
      tx_q    <= tx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_x_q <= '0;
      acc_y_q <= '0;
      acc_z_q <= '0;
    end else if (acc_en) begin
      acc_x_q <= x_word[AXIS_W-1:0];
      acc_y_q <= y_word[AXIS_W-1:0];
      acc_z_q <= z_word[AXIS_W-1:0];
    end
  end

  assign spi_start = start_q;
  assign spi_len   = len_q;
  assign spi_tx    = tx_q;
  assign acc_x     = acc_x_q;
  assign acc_y     = acc_y_q;
  assign acc_z     = acc_z_q;

  // Checker state: idle cycles of the SPI engine, and finished configuration frames.
  logic [GAP_W+1:0] idle_cnt;
  logic [1:0]       cfg_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      cfg_seen <= 2'd0;
    end else begin
      if (spi_busy) begin
        idle_cnt <= '0;
      end else if (idle_cnt != '1) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
      if (spi_done && (len_q == LEN_W'(CFG_BITS)) && (cfg_seen != 2'd2)) begin
        cfg_seen <= cfg_seen + 2'd1;
      end
    end
  end

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> (idle_cnt >= (GAP_W+2)'(GAP_CYC))); // R2
  AST_READ_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && (spi_len == LEN_W'(FRAME_W))) |-> (cfg_seen == 2'd2)); // R5
  AST_OUT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_x) |-> !spi_busy); // R7
  AST_AXES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(acc_y) || !$stable(acc_z)) |-> !spi_busy); // R7

endmodule

// File: rtl/accel_poll_ctrl.sv
`timescale 1ns/1ps
module accel_poll_ctrl
  import accel_poll_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned SCLK_MAX   = 8_000_000,
  parameter int unsigned GAP_NS     = 200,
  parameter logic [2:0]  RATE_CODE  = 3'b011,
  parameter logic [1:0]  RANGE_CODE = 2'b00,
  parameter int          AXIS_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic [AXIS_W-1:0] acc_x,
  output logic [AXIS_W-1:0] acc_y,
  output logic [AXIS_W-1:0] acc_z
);

  localparam int FRAME_W = 64;
  localparam int RX_W    = FRAME_W - HEAD_BITS;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam longint unsigned HALF_L =
    (longint'(CLK_HZ) + 2 * longint'(SCLK_MAX) - 1) / (2 * longint'(SCLK_MAX));
  localparam longint unsigned GAP_L =
    (longint'(CLK_HZ) * longint'(GAP_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int HALF_CYC = (HALF_L < 1) ? 1 : int'(HALF_L);
  localparam int GAP_CYC  = (GAP_L < 2) ? 2 : int'(GAP_L);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic               spi_start, spi_busy, spi_done;
  logic [LEN_W-1:0]   spi_len;
  logic [FRAME_W-1:0] spi_tx;
  logic [RX_W-1:0]    spi_rx;

  accel_seq #(
    .GAP_CYC   (GAP_CYC),
    .FRAME_W   (FRAME_W),
    .RX_W      (RX_W),
    .AXIS_W    (AXIS_W),
    .RATE_CODE (RATE_CODE),
    .RANGE_CODE(RANGE_CODE)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync),
    .spi_busy (spi_busy),
    .spi_done (spi_done),
    .rx_data  (spi_rx),
    .spi_start(spi_start),
    .spi_len  (spi_len),
    .spi_tx   (spi_tx),
    .acc_x    (acc_x),
    .acc_y    (acc_y),
    .acc_z    (acc_z)
  );

  accel_spi_engine #(
    .HALF_CYC(HALF_CYC),
    .FRAME_W (FRAME_W),
    .RX_W    (RX_W)
  ) u_spi (
    .clk    (clk),
    .rst_n  (rst_sync),
    .start  (spi_start),
    .len    (spi_len),
    .tx_data(spi_tx),
    .miso   (miso),
    .busy   (spi_busy),
    .done   (spi_done),
    .rx_data(spi_rx),
    .sclk   (sclk),
    .cs_n   (cs_n),
    .mosi   (mosi)
  );

endmodule

// File: tb/accel_slave_model.sv
`timescale 1ns/1ps
package tb_accel_pat_pkg;
  function automatic logic [11:0] axis_val(int n, int a);
    int v;
    case (a)
      0:       v = n * 293 + 17;
      1:       v = n * 611 + 1443;
      default: v = n * 1373 + 3087;
    endcase
    return 12'(v);
  endfunction

  // Six bytes XL XH YL YH ZL ZH; the upper nibble of each high byte is junk.
  function automatic logic [47:0] axis_bytes(int n);
    logic [47:0] b;
    for (int a = 0; a < 3; a++) begin
      logic [11:0] v;
      logic [3:0]  junk;
      v    = axis_val(n, a);
      junk = 4'(n + a + 5);
      b[47 - 16*a -: 16] = {v[7:0], junk, v[11:8]};
    end
    return b;
  endfunction
endpackage

module accel_slave_model
  import tb_accel_pat_pkg::*;
(
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  int          frame_cnt = 0;
  int          bit_cnt   = 0;
  int          last_len  = 0;
  int          mosi_viol = 0;
  int          cpol_viol = 0;
  logic [23:0] last_head = '0;
  logic [23:0] first_head = '0;
  logic [63:0] out_sh = '0;
  bit          in_frame = 0;
  bit          have_rise = 0;
  bit          have_sclk = 0;
  time         last_cs_rise = 0;
  time         last_sclk_rise = 0;
  time         min_gap = '1;
  time         min_per = '1;

  initial miso = 1'b0;

  always @(negedge cs_n) begin
    if (have_rise && (($time - last_cs_rise) < min_gap)) min_gap = $time - last_cs_rise;
    in_frame  = 1;
    bit_cnt   = 0;
    last_head = '0;
    have_sclk = 0;
    out_sh    = {16'h0000, axis_bytes(frame_cnt)};
    miso      = out_sh[63];
  end

  always @(posedge sclk) begin
    if (cs_n !== 1'b0) begin
      cpol_viol++;
    end else begin
      if (bit_cnt < 24) last_head = {last_head[22:0], mosi};
      bit_cnt++;
      if (have_sclk && (($time - last_sclk_rise) < min_per)) min_per = $time - last_sclk_rise;
      last_sclk_rise = $time;
      have_sclk      = 1;
    end
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      out_sh = {out_sh[62:0], 1'b0};
      miso   = out_sh[63];
    end
  end

  always @(posedge cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      last_len = bit_cnt;
      if (frame_cnt == 0) first_head = last_head;
      frame_cnt++;
      last_cs_rise = $time;
      have_rise    = 1;
    end
  end

  always @(mosi) begin
    if ((cs_n === 1'b0) && (sclk === 1'b1)) mosi_viol++;
  end
endmodule

// File: tb/tb_accel_poll_ctrl.sv
`timescale 1ns/1ps
module tb_accel_poll_ctrl;
  import tb_accel_pat_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n = 1'b0;
  logic sclk, cs_n, mosi, miso;
  logic [11:0] acc_x, acc_y, acc_z;
  logic sclk2, cs_n2, mosi2, miso2;
  logic [11:0] ax2, ay2, az2;

  accel_poll_ctrl dut (
    .clk(clk), .rst_n(rst_n), .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z)
  );
  accel_slave_model slv (.sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  accel_poll_ctrl #(.RATE_CODE(3'b101), .RANGE_CODE(2'b11)) dut2 (
    .clk(clk), .rst_n(rst_n), .miso(miso2), .sclk(sclk2), .cs_n(cs_n2), .mosi(mosi2),
    .acc_x(ax2), .acc_y(ay2), .acc_z(az2)
  );
  accel_slave_model slv2 (.sclk(sclk2), .cs_n(cs_n2), .mosi(mosi2), .miso(miso2));

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_frame_end();
    @(posedge cs_n);
    repeat (10) @(negedge clk);
  endtask

  task automatic check_axes(input string req, input int n);
    chk(acc_x == axis_val(n, 0), req, 64'(acc_x), 64'(axis_val(n, 0)));
    chk(acc_y == axis_val(n, 1), req, 64'(acc_y), 64'(axis_val(n, 1)));
    chk(acc_z == axis_val(n, 2), req, 64'(acc_z), 64'(axis_val(n, 2)));
  endtask

  task automatic check_cfg(input string req, input logic [23:0] exp);
    wait_frame_end();
    chk(slv.last_len == 24, req, 64'(slv.last_len), 64'd24);
    chk(slv.last_head == exp, req, 64'(slv.last_head), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL R7 watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1, "R1 cs_n", 64'(cs_n), 64'd1);
    chk(sclk === 1'b0, "R1 sclk", 64'(sclk), 64'd0);
    chk({acc_x, acc_y, acc_z} === 36'd0, "R1 buses", 64'({acc_x, acc_y, acc_z}), 64'd0);
    rst_n = 1'b1;

    check_cfg("R3 filter write", 24'h0A2C03);
    check_cfg("R4 power write", 24'h0A2D02);

    for (int r = 0; r < 8; r++) begin
      wait_frame_end();
      n = slv.frame_cnt - 1;
      chk(slv.last_len == 64, "R5 read length", 64'(slv.last_len), 64'd64);
      chk(slv.last_head[23:8] == 16'h0B0E, "R5 read header", 64'(slv.last_head[23:8]), 64'h0B0E);
      check_axes("R7 axes", n);
      @(negedge cs_n);
      #1;
      check_axes("R7 hold", n);
    end

    // R8 reset in the middle of a read frame
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cs_n === 1'b1, "R8 abort cs_n", 64'(cs_n), 64'd1);
    chk(sclk === 1'b0, "R8 abort sclk", 64'(sclk), 64'd0);
    chk({acc_x, acc_y, acc_z} === 36'd0, "R8 abort buses", 64'({acc_x, acc_y, acc_z}), 64'd0);
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    check_cfg("R8 reconfig filter", 24'h0A2C03);
    check_cfg("R8 reconfig power", 24'h0A2D02);
    wait_frame_end();
    n = slv.frame_cnt - 1;
    chk(slv.last_len == 64, "R8 read resumes", 64'(slv.last_len), 64'd64);
    check_axes("R8 axes after restart", n);

    // Whole-run bus properties
    chk(slv.min_gap >= 200, "R2 min cs gap", 64'(slv.min_gap), 64'd200);
    chk(slv.min_per >= 125, "R6 min sclk period", 64'(slv.min_per), 64'd125);
    chk(slv.mosi_viol == 0, "R6 mosi change while sclk high", 64'(slv.mosi_viol), 64'd0);
    chk(slv.cpol_viol == 0, "R6 sclk edge outside frame", 64'(slv.cpol_viol), 64'd0);
    // R3 with another range/rate setting
    chk(slv2.first_head == 24'h0A2CC5, "R3 alt codes", 64'(slv2.first_head), 64'h0A2CC5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule